// File: doc/BRIEF.md
# Power-Down Hold Wrapper for a Macrocell Array

This block surrounds a small array of configurable logic cells with a pin-controlled hold mode. Each cell forms the parity of a masked selection of array inputs (the gated logic inputs, one shared pin and the feedback of every cell register). It drives its output either straight from that term or from a register that captures it, with an optional inversion.

A static configuration bit decides what the shared pin does. When the bit is clear, the pin is an ordinary array input. When the bit is set, a high level on the pin stops the block: every other input is cut off from the array and the register clock is not accepted. All outputs and register states stay at the values they had when the hold began.

Inputs that are not driven keep their last driven level. On leaving the hold, inputs reach the array at once. The registers accept the clock again only after a programmable number of recovery cycles.

Top module: `pd_hold_array`

## Requirements
- R1: With `pd_en_i` = 0 the shared pin is array input bit N_IN. Its high level never freezes the block, and registers keep updating.
- R2: With `pd_en_i` = 1, a high level on the shared pin enters the hold. While `pd_en_i` = 1, array bit N_IN reads 0 whatever the pin level.
- R3: In any cycle where the hold is active, changes on `in_i` or `in_drv_i` leave every output unchanged. Combinatorial outputs keep their entry value.
- R4: In the hold the register clock is blocked, so every cell register and every registered output keeps its value.
- R5: An output that is unknown (X) when the hold begins stays unknown for the whole hold.
- R6: An input whose `in_drv_i` bit is 0 presents its last driven level to the array. Before any drive, that level is 0.
- R7: After the shared pin falls, inputs reach the array in the first low cycle. The registers ignore the next RECOV_CYC clock edges and update on the edge after those.
- R8: Cell register feedback (array bits N_IN+1 upward, cell j at N_IN+1+j) stays usable while `pd_en_i` = 1.
- R9: Cell j computes term = parity of (array vector AND its mask slice). Array bits 0..N_IN-1 are the inputs, bit N_IN is the shared pin and the upper bits are feedback. The output is (mode bit 1 ? register : term) XOR invert bit, and the register loads the term on each accepted edge.
- R10: While `rst_ni` is low, cell registers, keeper levels and the recovery count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pd_en_i | input | 1 | Configuration: shared pin acts as power-down control |
| shared_pin_i | input | 1 | Shared pin: array input or power-down request |
| in_i | input | N_IN | Logic input levels |
| in_drv_i | input | N_IN | Per-input driven flag; 0 means undriven (keeper holds) |
| mask_i | input | N_MC*(N_IN+1+N_MC) | Term masks, cell j in slice j |
| reg_mode_i | input | N_MC | Per-cell output source: 1 register, 0 term |
| inv_i | input | N_MC | Per-cell output inversion |
| out_o | output | N_MC | Cell outputs |

## Verification
The checker watches every cycle for three things. During a sustained hold, outputs and cell registers must stay unchanged, including unknown values. The recovery count must block the first edge after exit and never exceed its limit. The clock must be accepted whenever the feature is off and recovery is done. Only the bench scenarios can show the rest: that the shared pin steers a term when the feature is off and reads as 0 when it is on, that undriven inputs keep their level, that registers wait exactly RECOV_CYC edges after exit, and that feedback still steers logic with the feature on.

// File: rtl/pdh_pkg.sv
package pdh_pkg;
  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_src_e;
endpackage

// File: rtl/pdh_keeper.sv
module pdh_keeper #(
  parameter int N_IN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            block_i,
  input  logic [N_IN-1:0] pin_i,
  input  logic [N_IN-1:0] drv_i,
  output logic [N_IN-1:0] eff_o
);
  for (genvar i = 0; i < N_IN; i++) begin : g_bit
    logic kp_q;
    // blocked or undriven: present the kept level
    always_comb eff_o[i] = (block_i || !drv_i[i]) ? kp_q : pin_i[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) kp_q <= 1'b0;
      else         kp_q <= eff_o[i];
    end
  end
endmodule

// File: rtl/pdh_recovery.sv
module pdh_recovery #(
  parameter int RECOV_CYC = 3,
  parameter int CNT_W     = (RECOV_CYC > 0) ? $clog2(RECOV_CYC + 1) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             block_i,
  output logic             clk_ok_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RECOV_CYC);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (block_i)          cnt_q <= LOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign clk_ok_o = !block_i && (cnt_q == '0);
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/pdh_macrocell.sv
module pdh_macrocell
  import pdh_pkg::*;
#(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clk_ok_i,
  input  logic [W-1:0] vec_i,
  input  logic [W-1:0] mask_i,
  input  logic         mode_i,
  input  logic         inv_i,
  output logic         reg_o,
  output logic         out_o
);
  logic term;
  logic r_q;

  assign term = ^(vec_i & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       r_q <= 1'b0;
    else if (clk_ok_i) r_q <= term;
  end

  assign reg_o = r_q;
  assign out_o = ((mode_i == OUT_REG) ? r_q : term) ^ inv_i;
endmodule

// File: rtl/pd_hold_array.sv
module pd_hold_array #(
  parameter int N_IN      = 8,
  parameter int N_MC      = 4,
  parameter int RECOV_CYC = 3,
  localparam int W        = N_IN + 1 + N_MC,
  localparam int CNT_W    = (RECOV_CYC > 0) ? $clog2(RECOV_CYC + 1) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_en_i,
  input  logic              shared_pin_i,
  input  logic [N_IN-1:0]   in_i,
  input  logic [N_IN-1:0]   in_drv_i,
  input  logic [N_MC*W-1:0] mask_i,
  input  logic [N_MC-1:0]   reg_mode_i,
  input  logic [N_MC-1:0]   inv_i,
  output logic [N_MC-1:0]   out_o
);
  logic             blk;
  logic             clk_ok;
  logic [CNT_W-1:0] rcnt;
  logic [N_IN-1:0]  eff;
  logic             sp_bit;
  logic [N_MC-1:0]  reg_bus;
  logic [W-1:0]     vec;

  assign blk    = pd_en_i & shared_pin_i;
  // pin leaves the array when it serves as power-down control
  assign sp_bit = pd_en_i ? 1'b0 : shared_pin_i;
  assign vec    = {reg_bus, sp_bit, eff};

  pdh_keeper #(.N_IN(N_IN)) u_keeper (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .block_i (blk),
    .pin_i   (in_i),
    .drv_i   (in_drv_i),
    .eff_o   (eff)
  );

  pdh_recovery #(.RECOV_CYC(RECOV_CYC), .CNT_W(CNT_W)) u_recov (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .block_i  (blk),
    .clk_ok_o (clk_ok),
    .cnt_o    (rcnt)
  );

  for (genvar j = 0; j < N_MC; j++) begin : g_mc
    pdh_macrocell #(.W(W)) u_mc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clk_ok_i (clk_ok),
      .vec_i    (vec),
      .mask_i   (mask_i[j*W +: W]),
      .mode_i   (reg_mode_i[j]),
      .inv_i    (inv_i[j]),
      .reg_o    (reg_bus[j]),
      .out_o    (out_o[j])
    );
  end
endmodule

// File: rtl/pdh_checker.sv
module pdh_checker #(
  parameter int N_MC      = 4,
  parameter int RECOV_CYC = 3,
  parameter int CNT_W     = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pd_en_i,
  input logic             shared_pin_i,
  input logic [N_MC-1:0]  out_o,
  input logic [N_MC-1:0]  reg_bus,
  input logic             clk_ok,
  input logic [CNT_W-1:0] rcnt
);
  logic hold;
  assign hold = pd_en_i && shared_pin_i;

  p_freeze_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold && $past(hold)) |-> (out_o === $past(out_o)));

  p_reg_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold) |-> (reg_bus === $past(reg_bus)));

  // R7: first cycle after exit rejects the clock when recovery is configured
  p_exit_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((RECOV_CYC > 0) && !hold && $past(hold)) |-> !clk_ok);

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rcnt <= CNT_W'(RECOV_CYC)));

  p_no_pd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_en_i && rcnt == '0) |-> clk_ok);
endmodule

bind pd_hold_array pdh_checker #(
  .N_MC(N_MC), .RECOV_CYC(RECOV_CYC), .CNT_W(CNT_W)
) u_pdh_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pd_en_i      (pd_en_i),
  .shared_pin_i (shared_pin_i),
  .out_o        (out_o),
  .reg_bus      (reg_bus),
  .clk_ok       (clk_ok),
  .rcnt         (rcnt)
);

// File: tb/pd_hold_array_bench.sv
module pd_hold_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN  = 8;
  localparam int N_MC  = 4;
  localparam int RECOV = 3;
  localparam int W     = N_IN + 1 + N_MC;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              pd_en_i = 1'b0;
  logic              shared_pin_i = 1'b0;
  logic [N_IN-1:0]   in_i = '0;
  logic [N_IN-1:0]   in_drv_i = '0;
  logic [N_MC*W-1:0] mask_i;
  logic [N_MC-1:0]   reg_mode_i;
  logic [N_MC-1:0]   inv_i;
  logic [N_MC-1:0]   out_o;

  // cell0: reg, in0^fb0 (toggle); cell1: comb, pin^in1;
  // cell2: comb, fb0^in2; cell3: reg, in3, inverted
  assign mask_i     = {13'h008, 13'h204, 13'h102, 13'h201};
  assign reg_mode_i = 4'b1001;
  assign inv_i      = 4'b1000;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pd_hold_array #(.N_IN(N_IN), .N_MC(N_MC), .RECOV_CYC(RECOV)) u_pd_hold_array (
    .clk_i, .rst_ni, .pd_en_i, .shared_pin_i, .in_i, .in_drv_i,
    .mask_i, .reg_mode_i, .inv_i, .out_o
  );

  typedef struct {
    logic [N_MC-1:0] exp;
    string           tag;
  } item_t;
  item_t sb_q[$];

  int checks = 0;
  int errors = 0;

  logic [N_IN-1:0] m_kp  = '0;
  logic [N_MC-1:0] m_reg = '0;
  int              m_cnt = 0;

  function automatic logic [N_MC-1:0] model_out(logic [N_IN-1:0] eff, logic sp,
                                                logic [N_MC-1:0] r);
    logic [W-1:0]    v;
    logic [N_MC-1:0] o;
    v = {r, sp, eff};
    for (int j = 0; j < N_MC; j++) begin
      logic t;
      t = ^(v & mask_i[j*W +: W]);
      o[j] = (reg_mode_i[j] ? r[j] : t) ^ inv_i[j];
    end
    return o;
  endfunction

  task automatic step(input logic en, input logic pin, input logic [N_IN-1:0] din,
                      input logic [N_IN-1:0] drv, input string tag);
    logic            blk, sp, ok;
    logic [N_IN-1:0] eff;
    logic [W-1:0]    v;
    logic [N_MC-1:0] term;
    item_t           it;
    @(negedge clk_i);
    pd_en_i = en; shared_pin_i = pin; in_i = din; in_drv_i = drv;
    blk = en & pin;
    sp  = en ? 1'b0 : pin;
    for (int i = 0; i < N_IN; i++) eff[i] = (blk || !drv[i]) ? m_kp[i] : din[i];
    v = {m_reg, sp, eff};
    for (int j = 0; j < N_MC; j++) term[j] = ^(v & mask_i[j*W +: W]);
    ok = !blk && (m_cnt == 0);
    m_kp = eff;
    if (ok) m_reg = term;
    m_cnt = blk ? RECOV : ((m_cnt > 0) ? m_cnt - 1 : 0);
    it.exp = model_out(eff, sp, m_reg);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk_i);
      #3;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        checks++;
        if (out_o !== it.exp) begin
          errors++;
          $display("FAIL %s: out=%b expected=%b", it.tag, out_o, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk_i);
    checks++;
    if (out_o !== 4'b1000) begin
      errors++;
      $display("FAIL R10: reset out=%b expected=%b", out_o, 4'b1000);
    end
    rst_ni = 1'b1;
    // R9 / R1: toggle flop and pin as an ordinary input
    step(0, 0, 8'h01, 8'hFF, "R9");
    step(0, 0, 8'h01, 8'hFF, "R9");
    step(0, 1, 8'h09, 8'hFF, "R1");
    step(0, 1, 8'h0B, 8'hFF, "R1");
    step(0, 1, 8'h05, 8'hFF, "R1");
    step(0, 0, 8'h00, 8'hFF, "R9");
    // R6: undriven inputs keep their last level
    step(0, 0, 8'h0E, 8'h01, "R6");
    step(0, 0, 8'h0F, 8'h00, "R6");
    step(0, 0, 8'h08, 8'hFF, "R6");
    // R8 / R2: feature on, pin low; feedback still steers cell2
    step(1, 0, 8'h05, 8'hFF, "R8");
    step(1, 0, 8'h07, 8'hFF, "R8");
    // R2 / R3 / R4: hold entered, inputs change
    step(1, 1, 8'h00, 8'hFF, "R2");
    step(1, 1, 8'hFF, 8'hFF, "R3");
    step(1, 1, 8'h3C, 8'h0F, "R3");
    step(1, 1, 8'h01, 8'hFF, "R4");
    // R7: exit, inputs live at once, registers wait RECOV edges
    step(1, 0, 8'h03, 8'hFF, "R7");
    step(1, 0, 8'h01, 8'hFF, "R7");
    step(1, 0, 8'h03, 8'hFF, "R7");
    step(1, 0, 8'h09, 8'hFF, "R7");
    step(1, 0, 8'h09, 8'hFF, "R7");
    // R5: unknown combinatorial output held through a hold
    step(1, 0, 8'h00, 8'hFF, "R5");
    step(1, 0, {5'b0, 1'bx, 2'b0}, 8'hFF, "R5");
    step(1, 1, 8'h00, 8'hFF, "R5");
    step(1, 1, 8'h04, 8'hFF, "R5");
    step(1, 0, 8'h00, 8'hFF, "R5");
    step(0, 0, 8'h00, 8'hFF, "R9");
    step(0, 0, 8'h01, 8'hFF, "R9");
    repeat (3) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule